// File: doc/BRIEF.md
# Port Mirror Forwarding Filter

This block sits behind the forwarding lookup of a multi-port switch. It rewrites each frame's destination port mask so that a monitor port receives a copy of the traffic that enters on one chosen ingress port. When the receive side finishes a frame, it presents the ingress port, the destination bitmap from the lookup, the CRC error flag and the frame length, qualified by a one-cycle status strobe. One clock later the block returns the final destination bitmap and a drop flag. The drop flag is raised when no port at all is left to receive the frame.

Configuration is static. It consists of an enable bit, the ingress port to copy from, the port that receives the copies, and a debug mode. In the debug mode, damaged frames are also copied to the monitor port. A damaged frame is never sent to its normal destinations. Frames from any other ingress port pass through unchanged unless they are damaged.

Top module: `mirror_filter`

## Requirements
- R1: While reset is held, and after it is released with no strobe, `out_valid` is 0, `out_mask` is all zeros and `out_drop` is 0.
- R2: `out_valid` is high for exactly the cycle that follows a cycle in which `in_valid` was high. The outputs of that cycle reflect the inputs and configuration sampled with the strobe.
- R3: A good frame (no CRC error, length of at least `MIN_LEN` = 64 bytes) that did not arrive on the mirror source port leaves with its destination mask unchanged.
- R4: A good frame that arrived on the mirror source port while mirroring is active leaves with its destination mask plus the bit at index `cfg_mon_port`. Bit i of a mask stands for port i.
- R5: A frame with the CRC error flag set loses all its normal destinations. When `cfg_bad_mirror` is 0, it does not get the monitor bit either.
- R6: A frame whose length is below 64 bytes is treated as damaged in the same way as R5. A length of 63 is damaged and a length of 64 is good.
- R7: When `cfg_bad_mirror` is 1 and mirroring is active, a damaged frame from the mirror source port leaves with only the monitor bit set.
- R8: Mirroring is inactive when `cfg_mirror_en` is 0 or when `cfg_src_port` equals `cfg_mon_port`. The monitor bit is never added for a frame whose ingress port is the monitor port.
- R9: With `out_valid` high, `out_drop` is 1 exactly when `out_mask` is all zeros.
- R10: With `out_valid` low, `out_mask` is all zeros and `out_drop` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mirror_en | input | 1 | Enable for mirroring |
| cfg_bad_mirror | input | 1 | Debug mode: damaged frames from the source port also reach the monitor |
| cfg_src_port | input | PORT_W (3) | Ingress port whose traffic is copied |
| cfg_mon_port | input | PORT_W (3) | Port that receives the copies |
| in_valid | input | 1 | End-of-frame status strobe |
| in_src_port | input | PORT_W (3) | Ingress port of the frame |
| in_dest_mask | input | NUM_PORTS (8) | Destination bitmap from the lookup |
| in_crc_err | input | 1 | Frame failed its CRC check |
| in_frame_len | input | LEN_W (14) | Frame length in bytes |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_mask | output | NUM_PORTS (8) | Final destination bitmap |
| out_drop | output | 1 | No destination is left |

## Verification
The bench targets the length boundary at 63 and 64 bytes. A design that compares with the wrong relation would copy a runt frame to the monitor, or would discard a minimum-size good frame. It also covers the debug mode with a damaged frame. A design that only adds the monitor bit would still deliver a corrupt frame to its normal destinations.

The source-equals-monitor configuration and a cleared enable are both exercised. Getting either wrong would add a monitor bit that should not appear. The bench also checks frames whose lookup mask is already empty, where a design would have to raise the drop flag, and idle cycles, where a stale mask left on the outputs would show up.

// File: rtl/mirror_filter_pkg.sv
package mirror_filter_pkg;

   // Outcome of the frame screening stage
   typedef struct packed {
      logic crc_bad;
      logic runt;
   } screen_flags_t;

   function automatic logic flags_damaged(input screen_flags_t f);
      return f.crc_bad | f.runt;
   endfunction

endpackage

// File: rtl/frame_screen.sv
module frame_screen
   import mirror_filter_pkg::*;
#(
   parameter int LEN_W   = 14,
   parameter int MIN_LEN = 64
) (
   input  logic             crc_err,
   input  logic [LEN_W-1:0] frame_len,
   output screen_flags_t    flags,
   output logic             damaged
);

   if (LEN_W < 1) begin : g_chk_len_w
      $error("frame_screen: LEN_W must be at least 1");
   end
   if (MIN_LEN < 0 || MIN_LEN >= (1 << LEN_W)) begin : g_chk_min
      $error("frame_screen: MIN_LEN must fit in LEN_W bits");
   end

   logic runt_w;

   // Variant choice: length screening drops out entirely when MIN_LEN is zero
   if (MIN_LEN == 0) begin : g_no_len_check
      assign runt_w = 1'b0;
   end else begin : g_len_check
      localparam logic [LEN_W-1:0] MinLenV = LEN_W'(MIN_LEN);
      assign runt_w = (frame_len < MinLenV);
   end

   always_comb begin
      flags.crc_bad = crc_err;
      flags.runt    = runt_w;
      damaged       = flags_damaged(flags);
   end

   // R5: a CRC failure always marks the frame damaged
   always_comb begin
      a_r5_crc_marks_damaged: assert (!crc_err || damaged);
   end

endmodule

// File: rtl/mirror_select.sv
module mirror_select #(
   parameter int NUM_PORTS = 8,
   localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                 cfg_mirror_en,
   input  logic                 cfg_bad_mirror,
   input  logic [PORT_W-1:0]    cfg_src_port,
   input  logic [PORT_W-1:0]    cfg_mon_port,
   input  logic [PORT_W-1:0]    ing_port,
   input  logic                 damaged,
   output logic [NUM_PORTS-1:0] mon_vec
);

   logic pair_ok;
   logic from_src;
   logic take;

   // A monitor index beyond the port count disables mirroring
   assign pair_ok  = cfg_mirror_en
                   && (cfg_src_port != cfg_mon_port)
                   && (int'(cfg_mon_port) < NUM_PORTS);
   assign from_src = (ing_port == cfg_src_port) && (ing_port != cfg_mon_port);
   assign take     = pair_ok && from_src && (!damaged || cfg_bad_mirror);

   // One comparator per port decodes the monitor index
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mon_dec
      assign mon_vec[p] = take && (cfg_mon_port == PORT_W'(p));
   end

   // R4: at most one copy target is produced
   // R8: the ingress port never receives its own copy
   always_comb begin
      a_r4_single_monitor: assert ($onehot0(mon_vec));
      a_r8_no_self_copy:   assert (!(|mon_vec) || (ing_port != cfg_mon_port));
   end

endmodule

// File: rtl/mirror_filter.sv
module mirror_filter
   import mirror_filter_pkg::*;
#(
   parameter int NUM_PORTS = 8,
   parameter int LEN_W     = 14,
   parameter int MIN_LEN   = 64,
   localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_mirror_en,
   input  logic                 cfg_bad_mirror,
   input  logic [PORT_W-1:0]    cfg_src_port,
   input  logic [PORT_W-1:0]    cfg_mon_port,
   input  logic                 in_valid,
   input  logic [PORT_W-1:0]    in_src_port,
   input  logic [NUM_PORTS-1:0] in_dest_mask,
   input  logic                 in_crc_err,
   input  logic [LEN_W-1:0]     in_frame_len,
   output logic                 out_valid,
   output logic [NUM_PORTS-1:0] out_mask,
   output logic                 out_drop
);

   if (NUM_PORTS < 2) begin : g_chk_ports
      $error("mirror_filter: NUM_PORTS must be at least 2");
   end

   localparam logic [LEN_W-1:0] MinLenV = LEN_W'(MIN_LEN);

   screen_flags_t         flags;
   logic                  damaged;
   logic [NUM_PORTS-1:0]  mon_vec;
   logic [NUM_PORTS-1:0]  fwd_mask;
   logic [NUM_PORTS-1:0]  nxt_mask;

   frame_screen #(
      .LEN_W   (LEN_W),
      .MIN_LEN (MIN_LEN)
   ) u_screen (
      .crc_err   (in_crc_err),
      .frame_len (in_frame_len),
      .flags     (flags),
      .damaged   (damaged)
   );

   mirror_select #(
      .NUM_PORTS (NUM_PORTS)
   ) u_select (
      .cfg_mirror_en  (cfg_mirror_en),
      .cfg_bad_mirror (cfg_bad_mirror),
      .cfg_src_port   (cfg_src_port),
      .cfg_mon_port   (cfg_mon_port),
      .ing_port       (in_src_port),
      .damaged        (damaged),
      .mon_vec        (mon_vec)
   );

   // A damaged frame never reaches its lookup destinations
   assign fwd_mask = damaged ? '0 : in_dest_mask;
   assign nxt_mask = fwd_mask | mon_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_mask  <= '0;
         out_drop  <= 1'b0;
      end else if (in_valid) begin
         out_valid <= 1'b1;
         out_mask  <= nxt_mask;
         out_drop  <= ~|nxt_mask;
      end else begin
         out_valid <= 1'b0;
         out_mask  <= '0;
         out_drop  <= 1'b0;
      end
   end

   // R2: one result per strobe, one cycle later
   a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R5: a CRC failure in normal mode yields an empty mask
   a_r5_crc_screened: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_crc_err && !cfg_bad_mirror) |=> (out_mask == '0));

   // R3 and R8: with mirroring off, a good frame keeps its lookup mask
   a_r8_disabled_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cfg_mirror_en && !in_crc_err && (in_frame_len >= MinLenV))
      |=> (out_mask == $past(in_dest_mask)));

   // R7: debug mode sends a damaged source frame to the monitor only
   a_r7_bad_to_monitor_only: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cfg_mirror_en && cfg_bad_mirror && in_crc_err
       && (in_src_port == cfg_src_port) && (cfg_src_port != cfg_mon_port))
      |=> (out_mask == (NUM_PORTS'(1) << $past(cfg_mon_port))));

   // R9: drop flag matches an empty result
   a_r9_drop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_drop == (out_mask == '0)));

   // R10: idle outputs are quiet
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ((out_mask == '0) && !out_drop));

endmodule

// File: tb/mirror_filter_tb.sv
module mirror_filter_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NP         = 8;
   localparam int PW         = 3;
   localparam int LW         = 14;
   localparam int MINL       = 64;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_mirror_en;
   logic          cfg_bad_mirror;
   logic [PW-1:0] cfg_src_port;
   logic [PW-1:0] cfg_mon_port;
   logic          in_valid;
   logic [PW-1:0] in_src_port;
   logic [NP-1:0] in_dest_mask;
   logic          in_crc_err;
   logic [LW-1:0] in_frame_len;
   logic          out_valid;
   logic [NP-1:0] out_mask;
   logic          out_drop;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mirror_filter #(
      .NUM_PORTS (NP),
      .LEN_W     (LW),
      .MIN_LEN   (MINL)
   ) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_mirror_en  (cfg_mirror_en),
      .cfg_bad_mirror (cfg_bad_mirror),
      .cfg_src_port   (cfg_src_port),
      .cfg_mon_port   (cfg_mon_port),
      .in_valid       (in_valid),
      .in_src_port    (in_src_port),
      .in_dest_mask   (in_dest_mask),
      .in_crc_err     (in_crc_err),
      .in_frame_len   (in_frame_len),
      .out_valid      (out_valid),
      .out_mask       (out_mask),
      .out_drop       (out_drop)
   );

   // Reference result: {drop, mask}
   function automatic logic [NP:0] model_result(
      input logic en, input logic bm,
      input logic [PW-1:0] cs, input logic [PW-1:0] cm,
      input logic [PW-1:0] src, input logic [NP-1:0] dm,
      input logic crc, input logic [LW-1:0] len);
      logic          bad;
      logic [NP-1:0] m;
      bad = crc || (len < LW'(MINL));
      m   = bad ? '0 : dm;
      if (en && (cs != cm) && (src == cs) && (!bad || bm))
         m[cm] = 1'b1;
      return {(m == '0), m};
   endfunction

   function automatic string pick_tag(
      input logic en, input logic bm,
      input logic [PW-1:0] cs, input logic [PW-1:0] cm,
      input logic [PW-1:0] src, input logic crc, input logic [LW-1:0] len);
      logic bad;
      bad = crc || (len < LW'(MINL));
      if (src == cs && (!en || cs == cm)) return "R8";
      if (bad && bm && en && cs != cm && src == cs) return "R7";
      if (crc) return "R5";
      if (bad) return "R6";
      if (src == cs) return "R4";
      return "R3";
   endfunction

   task automatic check_bit(input string tag, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // Drive one frame status, wait for the result, and check it
   task automatic send(input logic en, input logic bm,
                       input logic [PW-1:0] cs, input logic [PW-1:0] cm,
                       input logic [PW-1:0] src, input logic [NP-1:0] dm,
                       input logic crc, input logic [LW-1:0] len,
                       input string tag);
      logic [NP:0] exp;
      cfg_mirror_en  = en;
      cfg_bad_mirror = bm;
      cfg_src_port   = cs;
      cfg_mon_port   = cm;
      in_valid       = 1'b1;
      in_src_port    = src;
      in_dest_mask   = dm;
      in_crc_err     = crc;
      in_frame_len   = len;
      exp = model_result(en, bm, cs, cm, src, dm, crc, len);
      @(negedge clk);
      in_valid = 1'b0;
      check_bit("R2", "out_valid", 32'(out_valid), 32'd1);
      check_bit(tag, "out_mask", 32'(out_mask), 32'(exp[NP-1:0]));
      check_bit("R9", "out_drop", 32'(out_drop), 32'(exp[NP]));
   endtask

   task automatic idle_check();
      in_valid     = 1'b0;
      in_dest_mask = 8'hFF;
      @(negedge clk);
      check_bit("R2", "idle out_valid", 32'(out_valid), 32'd0);
      check_bit("R10", "idle out_mask", 32'(out_mask), 32'd0);
      check_bit("R10", "idle out_drop", 32'(out_drop), 32'd0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int unsigned seed_val;
      seed_val       = $urandom(32'd20240611);
      rst_n          = 1'b0;
      cfg_mirror_en  = 1'b0;
      cfg_bad_mirror = 1'b0;
      cfg_src_port   = '0;
      cfg_mon_port   = '0;
      in_valid       = 1'b1;
      in_src_port    = '0;
      in_dest_mask   = 8'hFF;
      in_crc_err     = 1'b0;
      in_frame_len   = 14'd100;
      repeat (3) @(negedge clk);
      // R1: reset holds outputs quiet even with a strobe present
      check_bit("R1", "reset out_valid", 32'(out_valid), 32'd0);
      check_bit("R1", "reset out_mask", 32'(out_mask), 32'd0);
      check_bit("R1", "reset out_drop", 32'(out_drop), 32'd0);
      in_valid = 1'b0;
      rst_n    = 1'b1;
      @(negedge clk);
      check_bit("R1", "post-reset out_valid", 32'(out_valid), 32'd0);
      check_bit("R1", "post-reset out_mask", 32'(out_mask), 32'd0);

      // Directed corner cases; mirror source 2, monitor 5
      send(1, 0, 3'd2, 3'd5, 3'd1, 8'h0C, 0, 14'd200, "R3");
      send(1, 0, 3'd2, 3'd5, 3'd2, 8'h09, 0, 14'd200, "R4");
      send(1, 0, 3'd2, 3'd5, 3'd2, 8'h09, 1, 14'd200, "R5");
      send(1, 0, 3'd2, 3'd5, 3'd2, 8'h09, 0, 14'd63,  "R6");
      send(1, 0, 3'd2, 3'd5, 3'd2, 8'h09, 0, 14'd64,  "R6");
      send(1, 0, 3'd2, 3'd5, 3'd3, 8'h41, 0, 14'd63,  "R6");
      send(1, 1, 3'd2, 3'd5, 3'd2, 8'h09, 1, 14'd500, "R7");
      send(1, 1, 3'd2, 3'd5, 3'd2, 8'h09, 0, 14'd10,  "R7");
      send(1, 1, 3'd2, 3'd5, 3'd4, 8'h09, 1, 14'd500, "R7");
      send(0, 0, 3'd2, 3'd5, 3'd2, 8'h09, 0, 14'd200, "R8");
      send(1, 0, 3'd4, 3'd4, 3'd4, 8'h03, 0, 14'd200, "R8");
      send(1, 0, 3'd2, 3'd5, 3'd5, 8'h03, 0, 14'd200, "R8");
      send(1, 0, 3'd2, 3'd5, 3'd1, 8'h00, 0, 14'd200, "R9");
      send(1, 0, 3'd2, 3'd5, 3'd2, 8'h00, 0, 14'd200, "R9");
      send(1, 0, 3'd2, 3'd5, 3'd2, 8'h20, 0, 14'd64,  "R4");
      idle_check();
      send(1, 0, 3'd7, 3'd0, 3'd7, 8'h80, 0, 14'd1518, "R4");
      idle_check();

      // Constrained random frames
      for (int i = 0; i < 3000; i++) begin
         logic          en, bm, crc;
         logic [PW-1:0] cs, cm, src;
         logic [NP-1:0] dm;
         logic [LW-1:0] len;
         en  = ($urandom % 8) != 0;
         bm  = ($urandom % 3) == 0;
         cs  = PW'($urandom);
         cm  = (($urandom % 10) == 0) ? cs : PW'($urandom);
         src = (($urandom % 2) == 0) ? cs : PW'($urandom);
         dm  = NP'($urandom);
         crc = ($urandom % 6) == 0;
         if (($urandom % 4) == 0) len = LW'(56 + ($urandom % 16));
         else                     len = LW'(64 + ($urandom % 1455));
         send(en, bm, cs, cm, src, dm, crc, len,
              pick_tag(en, bm, cs, cm, src, crc, len));
         if (($urandom % 16) == 0) idle_check();
      end

      idle_check();
      finish_run();
   end

endmodule